// File: doc/BRIEF.md
# Iterative Lowest-Set-Bit Finder

This block reports where the least significant one sits in a wide input word. It does not use one flat priority encoder across all bits. When a start request is accepted, it latches the word. It then spends one clock per step halving a search window. Each step OR-reduces the low half and the high half of the window and keeps the half that holds the lowest one. When a single bit is left, the block writes the answer into a result register and pulses a completion flag.

The answer is one-based: bit 0 gives 1, and bit WIDTH-1 gives WIDTH. An all-zero word gives 0. A caller raises `start` for one cycle while `busy` is low. It then waits for `done` and reads `lowIdx`. The value in `lowIdx` stays put until the next search completes.

Top module: `lsb_bsearch`

## Requirements
- R1: `lowIdx` is one plus the bit position of the least significant one in the latched word. Examples: bits 3 and 7 set gives 4, bit 0 alone gives 1, and bit WIDTH-1 alone gives WIDTH.
- R2: A latched word with no bit set yields `lowIdx` = 0.
- R3: When both halves of the window hold a one, the search keeps the lower half. A one in a higher position never changes the answer.
- R4: The word on `dataIn` is captured only on the clock edge that accepts `start`. Later changes to `dataIn` do not affect the running search.
- R5: Suppose `start` is accepted at edge k. Then `lowIdx` is updated and `done` is high right after edge k+log2(WIDTH)+1.
- R6: `busy` rises at the edge that accepts `start` and falls at the edge that raises `done`. A `start` seen while `busy` is high is ignored and does not change the timing or the result. A `start` in the cycle when `done` is high is accepted.
- R7: `done` is high for exactly one cycle per search. `lowIdx` changes only on that edge.
- R8: Synchronous active-high `rst` clears `lowIdx`, `busy` and `done`, aborts any search and returns the block to idle.
- R9: WIDTH is a power of two, at least 4. `lowIdx` is log2(WIDTH)+1 bits wide, so it can hold the value WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Search request, accepted only while idle |
| dataIn | input | WIDTH | Word to search, latched when a request is accepted |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when `lowIdx` is updated |
| lowIdx | output | log2(WIDTH)+1 | One-based position of the lowest one, 0 when none |

## Verification
Two events can fall in the same cycle. One is the completion of a search, with `done` high and `busy` just dropped. The other is a new `start` request. The bench raises `start` exactly in the cycle where it sees `done`. It then expects four things on the following edge: the new request is accepted, `busy` is high again, `done` is low, and `lowIdx` still holds the finished answer. A second case holds `start` high through most of a search and checks that neither the completion time nor the answer moves.

// File: rtl/lsb_bsearch_pkg.sv
package lsb_bsearch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_REPORT = 2'd2
  } searchState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;    // capture the input word, reset the window
    logic step;    // perform one halving step
    logic report;  // write the result register
  } dpStrobe_t;

endpackage

// File: rtl/lsb_bsearch_ctrl.sv
module lsb_bsearch_ctrl
  import lsb_bsearch_pkg::*;
#(
  parameter int STEPS = 9,
  parameter int STEPW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output dpStrobe_t        strobe,
  output logic [STEPW-1:0] stepIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(STEPS - 1);

  searchState_t     state, stateNext;
  logic [STEPW-1:0] stepCnt;
  logic             doneQ;

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start;
    strobe.step   = (state == ST_SEARCH);
    strobe.report = (state == ST_REPORT);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (start) stateNext = ST_SEARCH;
      ST_SEARCH: if (stepCnt == LAST_STEP) stateNext = ST_REPORT;
      ST_REPORT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= strobe.report;
      if (strobe.load)      stepCnt <= '0;
      else if (strobe.step) stepCnt <= stepCnt + STEPW'(1);
    end
  end

  assign stepIdx = stepCnt;
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;

  // R7: completion flag never lasts two cycles
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R6: busy and done are never high together
  assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(busy && doneQ));

  // R6: a search in progress advances one step per cycle regardless of start
  assert_search_advances_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH && stepCnt != LAST_STEP) |=>
      (state == ST_SEARCH && stepCnt == $past(stepCnt) + STEPW'(1)));

  // R5: last step always leads to the report state
  assert_last_step_reports_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH && stepCnt == LAST_STEP) |=> (state == ST_REPORT));

endmodule

// File: rtl/lsb_bsearch_dp.sv
module lsb_bsearch_dp
  import lsb_bsearch_pkg::*;
#(
  parameter int WIDTH = 512,
  parameter int STEPS = 9,
  parameter int STEPW = 4,
  parameter int IDXW  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [STEPW-1:0] stepIdx,
  input  logic [WIDTH-1:0] dataIn,
  output logic [IDXW-1:0]  lowIdx
);

  localparam int SLOTS = 1 << STEPW;

  logic [WIDTH-1:0] winBits;    // window, always aligned to bit 0
  logic [STEPS-1:0] baseIdx;    // absolute position of window bit 0
  logic             anyFlag;    // latched word had at least one set bit
  logic [IDXW-1:0]  resultQ;

  logic [SLOTS-1:0] lowAnyVec;
  logic [WIDTH-1:0] shiftedWin [SLOTS];

  // one constant-size lower-half reduction and shift per step
  for (genvar s = 0; s < SLOTS; s++) begin : g_step
    if (s < STEPS) begin : g_real
      localparam int HALF = WIDTH >> (s + 1);
      assign lowAnyVec[s]  = |winBits[HALF-1:0];
      assign shiftedWin[s] = winBits >> HALF;
    end else begin : g_pad
      assign lowAnyVec[s]  = 1'b1;
      assign shiftedWin[s] = winBits;
    end
  end

  logic             lowAny;
  logic [WIDTH-1:0] upperWin;
  logic [STEPS-1:0] halfAmt;
  int               shAmt;

  always_comb begin
    lowAny   = lowAnyVec[stepIdx];
    upperWin = shiftedWin[stepIdx];
    shAmt    = STEPS - 1 - int'(stepIdx);
    halfAmt  = {{(STEPS-1){1'b0}}, 1'b1} << shAmt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winBits <= '0;
      baseIdx <= '0;
      anyFlag <= 1'b0;
      resultQ <= '0;
    end else begin
      if (strobe.load) begin
        winBits <= dataIn;
        baseIdx <= '0;
        anyFlag <= |dataIn;
      end else if (strobe.step && !lowAny) begin
        // lower half empty: move window to the upper half
        winBits <= upperWin;
        baseIdx <= baseIdx + halfAmt;
      end
      if (strobe.report) begin
        if (anyFlag) resultQ <= {1'b0, baseIdx} + IDXW'(1);
        else         resultQ <= '0;
      end
    end
  end

  assign lowIdx = resultQ;

  // R7: result holds unless a report strobe arrives
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe.report |=> $stable(resultQ));

  // R2: empty word reports zero
  assert_zero_report_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.report && !anyFlag) |=> (resultQ == '0));

  // R1: at report time the surviving bit must be set
  assert_final_bit_set_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe.report && anyFlag) |-> winBits[0]);

  // R3: a populated lower half keeps the window where it is
  assert_prefer_lower_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.step && !strobe.load && lowAny) |=> $stable(baseIdx));

endmodule

// File: rtl/lsb_bsearch.sv
module lsb_bsearch
  import lsb_bsearch_pkg::*;
#(
  parameter int WIDTH = 512,
  localparam int STEPS = $clog2(WIDTH),
  localparam int STEPW = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int IDXW  = STEPS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dataIn,
  output logic             busy,
  output logic             done,
  output logic [IDXW-1:0]  lowIdx
);

  // R9: power-of-two width of at least four bits
  initial begin
    assert_width_pow2_R9: assert ((WIDTH >= 4) && ((1 << STEPS) == WIDTH));
  end

  dpStrobe_t        strobe;
  logic [STEPW-1:0] stepIdx;

  lsb_bsearch_ctrl #(
    .STEPS (STEPS),
    .STEPW (STEPW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .busy    (busy),
    .done    (done)
  );

  lsb_bsearch_dp #(
    .WIDTH (WIDTH),
    .STEPS (STEPS),
    .STEPW (STEPW),
    .IDXW  (IDXW)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .stepIdx (stepIdx),
    .dataIn  (dataIn),
    .lowIdx  (lowIdx)
  );

endmodule

// File: tb/tb_lsb_bsearch.sv
`timescale 1ns/1ps
module tb_lsb_bsearch;

  localparam int W     = 512;
  localparam int STEPS = $clog2(W);
  localparam int IDXW  = STEPS + 1;
  localparam int LAT   = STEPS + 2;   // negedges from drive to done

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  dataIn = '0;
  logic          busy, done;
  logic [IDXW-1:0] lowIdx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  lsb_bsearch #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start(start), .dataIn(dataIn),
    .busy(busy), .done(done), .lowIdx(lowIdx)
  );

  function automatic int lowestOne(logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  // behavioural reference model
  int mBusy = 0, mDone = 0, mResult = 0, mHeld = 0, mCount = 0;
  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mDone = 0; mResult = 0; mCount = 0;
    end else begin
      mDone = 0;
      if (mBusy != 0) begin
        mCount = mCount - 1;
        if (mCount == 0) begin
          mBusy = 0; mDone = 1; mResult = mHeld;
        end
      end else if (start) begin
        mHeld = lowestOne(dataIn);
        mBusy = 1;
        mCount = STEPS + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(lowIdx) == mResult, "R1/R4 lowIdx vs model", int'(lowIdx), mResult);
      check(int'(busy) == mBusy, "R6 busy vs model", int'(busy), mBusy);
      check(int'(done) == mDone, "R7 done vs model", int'(done), mDone);
    end
  end

  // returns negedges from drive until done seen
  task automatic search(input logic [W-1:0] v, input bit scramble, output int lat);
    lat = 0;
    @(negedge clk);
    start = 1'b1; dataIn = v;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (scramble) dataIn = {16{$urandom()}};
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(lowIdx == '0, "R8 reset lowIdx", int'(lowIdx), 0);
    check(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    check(done == 1'b0, "R8 reset done", int'(done), 0);
    rst = 1'b0;

    // R1 example and R5 latency
    search(W'(8'h88), 0, lat);
    check(int'(lowIdx) == 4, "R1 bits 3 and 7", int'(lowIdx), 4);
    check(lat == LAT, "R5 latency", lat, LAT);

    // R2 empty word
    search('0, 0, lat);
    check(lowIdx == '0, "R2 empty word", int'(lowIdx), 0);

    // R1 boundaries, R9 full-width value
    search(W'(1), 0, lat);
    check(int'(lowIdx) == 1, "R1 bit 0", int'(lowIdx), 1);
    v = '0; v[W-1] = 1'b1;
    search(v, 0, lat);
    check(int'(lowIdx) == W, "R9 top bit value", int'(lowIdx), W);

    // R3 both halves populated
    v = '0; v[5] = 1'b1; v[300] = 1'b1; v[W-1] = 1'b1;
    search(v, 0, lat);
    check(int'(lowIdx) == 6, "R3 lower half wins", int'(lowIdx), 6);

    // R4 input changes during search
    v = '0; v[200] = 1'b1; v[450] = 1'b1;
    search(v, 1, lat);
    check(int'(lowIdx) == 201, "R4 latched word", int'(lowIdx), 201);

    // R6 start held while busy
    v = '0; v[77] = 1'b1;
    @(negedge clk);
    start = 1'b1; dataIn = v;
    @(negedge clk);
    dataIn = W'(1);
    lat = 1;
    while (!done && lat < 100) begin
      if (lat == LAT - 2) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(int'(lowIdx) == 78, "R6 start while busy ignored", int'(lowIdx), 78);
    check(lat == LAT, "R6 timing unchanged", lat, LAT);

    // R6/R7 new start in the done cycle
    v = '0; v[33] = 1'b1;
    search(v, 0, lat);
    start = 1'b1; dataIn = W'(2);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 start in done cycle accepted", int'(busy), 1);
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    check(int'(lowIdx) == 34, "R7 result held", int'(lowIdx), 34);
    while (!done) @(negedge clk);
    check(int'(lowIdx) == 2, "R1 back-to-back result", int'(lowIdx), 2);

    // random sparse words
    for (int n = 0; n < 24; n++) begin
      v = '0;
      for (int k = 0; k < (n % 4); k++) v[$urandom_range(W-1, 0)] = 1'b1;
      search(v, n[0], lat);
      check(int'(lowIdx) == lowestOne(v), "R1 random word", int'(lowIdx), lowestOne(v));
    end

    // R8 reset in the middle of a search
    @(negedge clk);
    start = 1'b1; dataIn = W'(16);
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0, "R8 reset aborts busy", int'(busy), 0);
    check(lowIdx == '0, "R8 reset clears result", int'(lowIdx), 0);
    repeat (LAT + 2) @(negedge clk);
    check(done == 1'b0, "R8 no late done", int'(done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule